// File: doc/BRIEF.md
# Upper Memory Bank-Switch Controller

This block sits between an 8-bit CPU's 16-bit address bus and the memory of the top 12 KB of the address space, $D000 to $FFFF. For every access it decides whether a read is served from ROM or from RAM, and whether a write may reach RAM. It also produces the physical RAM address. The 4 KB window $D000 to $DFFF is banked. Bank 2 lives at physical $D000 to $DFFF. Bank 1 is relocated into the physical $C000 to $CFFF page. The region $E000 to $FFFF is not banked and always maps to itself.

The configuration is set by touching a 16-address soft-switch window at $C080 to $C08F. Reads and writes both count, and the data value plays no part. Address bit 3 picks the bank. Address bits 1:0 pick one of four combinations of read source and write protection. Address bit 2 is ignored. Writes can reach RAM even while reads come from ROM, which allows ROM contents to be copied into the RAM underneath them. The current read-source, protection and bank flags are brought out as outputs.

Top module: `upper_bank_switch`

## Requirements
- R1: A synchronous active-high reset sets the cold-start configuration: reads from ROM (`cfg_read_ram`=0), writes allowed (`cfg_wprot`=0), bank 2 selected (`cfg_bank1`=0).
- R2: A read in $D000 to $FFFF while ROM reads are selected asserts `rom_sel` and does not assert `ram_we`.
- R3: A write in $D000 to $FFFF with protection off asserts `ram_we`, whatever the read source is.
- R4: With bank 1 selected, an access to $D000 to $DFFF produces physical address $C000 + offset. With bank 2 selected it produces $D000 + offset.
- R5: Accesses to $E000 to $FFFF produce a physical address equal to the CPU address, whatever bank is selected.
- R6: A soft-switch access with address bit 3 = 1 selects bank 1 (`cfg_bank1`=1). Bit 3 = 0 selects bank 2. The new value is visible after the clock edge that samples the access.
- R7: Address bits 1:0 of a soft-switch access set the mode. 00 means RAM read with writes protected. 01 means ROM read with writes enabled. 10 means ROM read with writes protected. 11 means RAM read with writes enabled.
- R8: Address bit 2 of a soft-switch access has no effect: $C084-$C087 and $C08C-$C08F give the same configuration as the address with bit 2 cleared.
- R9: With protection on, a write in $D000 to $FFFF does not assert `ram_we`.
- R10: A read in $D000 to $FFFF while RAM reads are selected leaves `rom_sel` low. A read of $D000 yields physical $C000 or $D000 depending only on the current bank.
- R11: A soft-switch access, read or write, updates the configuration and asserts neither `ram_we` nor `rom_sel`.
- R12: An access below $D000 outside the soft-switch window passes its address through unchanged, asserts `ram_we` only for a write, never asserts `rom_sel`, and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | An access is present this cycle |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 16 | CPU address |
| ram_addr | output | 16 | Physical RAM address for the access |
| ram_we | output | 1 | RAM write enable |
| rom_sel | output | 1 | Read data must come from ROM |
| cfg_read_ram | output | 1 | Current read source: 1 = RAM, 0 = ROM |
| cfg_wprot | output | 1 | Current write protection of $D000 to $FFFF |
| cfg_bank1 | output | 1 | Current bank: 1 = bank 1, 0 = bank 2 |

## Verification
All sixteen soft-switch addresses are tried as reads and as writes. This separates the role of bit 3, which selects the bank, from bits 1:0, which select the mode, and confirms that bit 2 is ignored. The same access in $D000, $DFFF, $E000 and $FFFF is repeated under each bank and mode. This tells the relocated bank 1 apart from bank 2 and from the fixed region, and shows ROM reads apart from write-through and protected writes. Accesses at $0000, $C07F, $C090 and $CFFF check that addresses next to the window neither remap nor change the configuration.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

    typedef struct packed {
        logic read_ram;   // 1: reads of the upper area come from RAM
        logic wprot;      // 1: writes to the upper area are dropped
        logic bank1;      // 1: bank 1 occupies the banked window
    } bank_cfg_t;

    typedef enum logic [1:0] {
        REG_LOW    = 2'd0,
        REG_SWITCH = 2'd1,
        REG_BANKED = 2'd2,
        REG_FIXED  = 2'd3
    } region_e;

    localparam bank_cfg_t COLD_CFG = '{read_ram: 1'b0, wprot: 1'b0, bank1: 1'b0};

    // sel = {bank bit, mode bits}; the ignored address bit is never passed in
    function automatic bank_cfg_t decode_switch(input logic [2:0] sel);
        bank_cfg_t c;
        c.bank1    = sel[2];
        c.read_ram = (sel[1:0] == 2'b00) || (sel[1:0] == 2'b11);
        c.wprot    = (sel[1:0] == 2'b00) || (sel[1:0] == 2'b10);
        return c;
    endfunction

endpackage

// File: rtl/ubs_region_decode.sv
module ubs_region_decode
    import ubs_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          PAGE_W      = 4,
    parameter int          SEL_W       = 4,
    parameter logic [15:0] SW_BASE     = 16'hC080,
    parameter logic [3:0]  BANKED_PAGE = 4'hD
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int HI_W = ADDR_W - SEL_W;

    logic [PAGE_W-1:0] page;
    logic [HI_W-1:0]   hi_bits;
    logic [HI_W-1:0]   sw_hi;

    assign page    = addr[ADDR_W-1 -: PAGE_W];
    assign hi_bits = addr[ADDR_W-1 -: HI_W];
    assign sw_hi   = SW_BASE[ADDR_W-1 -: HI_W];

    always_comb begin
        if (hi_bits == sw_hi)
            region = REG_SWITCH;
        else if (page == BANKED_PAGE[PAGE_W-1:0])
            region = REG_BANKED;
        else if (page > BANKED_PAGE[PAGE_W-1:0])
            region = REG_FIXED;
        else
            region = REG_LOW;
    end
endmodule

// File: rtl/ubs_cfg_reg.sv
module ubs_cfg_reg
    import ubs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_hit,
    input  logic [2:0] sw_sel,
    output bank_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= COLD_CFG;
        else if (sw_hit)
            cfg <= decode_switch(sw_sel);
    end
endmodule

// File: rtl/ubs_addr_map.sv
module ubs_addr_map
    import ubs_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         PAGE_W     = 4,
    parameter logic [3:0] BANK1_PAGE = 4'hC
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  region_e           region,
    input  bank_cfg_t         cfg,
    output logic [ADDR_W-1:0] phys,
    output logic              ram_we,
    output logic              rom_sel
);
    localparam int OFF_W = ADDR_W - PAGE_W;

    logic upper;
    assign upper = (region == REG_BANKED) || (region == REG_FIXED);

    always_comb begin
        phys = addr;
        if (region == REG_BANKED && cfg.bank1)
            phys = {BANK1_PAGE[PAGE_W-1:0], addr[OFF_W-1:0]};
    end

    always_comb begin
        ram_we  = 1'b0;
        rom_sel = 1'b0;
        if (valid) begin
            unique case (region)
                REG_LOW:    ram_we = we;
                REG_SWITCH: ram_we = 1'b0;
                default: begin
                    ram_we  = we && !cfg.wprot;
                    rom_sel = !we && !cfg.read_ram;
                end
            endcase
        end
    end

    logic unused_upper;
    assign unused_upper = upper;
endmodule

// File: rtl/upper_bank_switch.sv
module upper_bank_switch
    import ubs_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] SW_BASE     = 16'hC080,
    parameter logic [3:0]  BANKED_PAGE = 4'hD,
    parameter logic [3:0]  BANK1_PAGE  = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              rom_sel,
    output logic              cfg_read_ram,
    output logic              cfg_wprot,
    output logic              cfg_bank1
);
    localparam int PAGE_W = 4;
    localparam int SEL_W  = 4;

    region_e   region;
    bank_cfg_t cfg;
    logic      sw_hit;
    logic [2:0] sw_sel;

    ubs_region_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W),
        .SW_BASE(SW_BASE), .BANKED_PAGE(BANKED_PAGE)
    ) u_region (
        .addr  (cpu_addr),
        .region(region)
    );

    assign sw_hit = cpu_valid && (region == REG_SWITCH);
    assign sw_sel = {cpu_addr[3], cpu_addr[1:0]};

    ubs_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .sw_hit(sw_hit),
        .sw_sel(sw_sel),
        .cfg   (cfg)
    );

    ubs_addr_map #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK1_PAGE(BANK1_PAGE)
    ) u_map (
        .valid  (cpu_valid),
        .we     (cpu_we),
        .addr   (cpu_addr),
        .region (region),
        .cfg    (cfg),
        .phys   (ram_addr),
        .ram_we (ram_we),
        .rom_sel(rom_sel)
    );

    assign cfg_read_ram = cfg.read_ram;
    assign cfg_wprot    = cfg.wprot;
    assign cfg_bank1    = cfg.bank1;
endmodule

// File: rtl/ubs_checker.sv
module ubs_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_valid,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [15:0] ram_addr,
    input logic        ram_we,
    input logic        rom_sel,
    input logic        cfg_read_ram,
    input logic        cfg_wprot,
    input logic        cfg_bank1
);
    logic is_sw, is_upper, is_banked, is_fixed;
    assign is_sw     = cpu_valid && (cpu_addr[15:4] == 12'hC08);
    assign is_banked = cpu_addr[15:12] == 4'hD;
    assign is_fixed  = cpu_addr[15:12] >= 4'hE;
    assign is_upper  = cpu_valid && (is_banked || is_fixed);

    // R1
    cold_reset_chk: assert property (@(posedge clk)
        rst |=> (!cfg_read_ram && !cfg_wprot && !cfg_bank1));

    // R2
    rom_read_chk: assert property (@(posedge clk) disable iff (rst)
        (is_upper && !cpu_we && !cfg_read_ram) |-> (rom_sel && !ram_we));

    // R3
    write_through_chk: assert property (@(posedge clk) disable iff (rst)
        (is_upper && cpu_we && !cfg_wprot) |-> ram_we);

    // R4
    bank1_reloc_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && is_banked && cfg_bank1) |-> (ram_addr == {4'hC, cpu_addr[11:0]}));

    // R5
    fixed_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && is_fixed) |-> (ram_addr == cpu_addr));

    // R6
    bank_bit_chk: assert property (@(posedge clk) disable iff (rst)
        is_sw |=> (cfg_bank1 == $past(cpu_addr[3])));

    // R7
    mode_bits_chk: assert property (@(posedge clk) disable iff (rst)
        is_sw |=> (cfg_read_ram == ($past(cpu_addr[1]) == $past(cpu_addr[0]))
                   && cfg_wprot == !$past(cpu_addr[0])));

    // R9
    protect_chk: assert property (@(posedge clk) disable iff (rst)
        (is_upper && cpu_we && cfg_wprot) |-> !ram_we);

    // R11
    switch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_sw |-> (!ram_we && !rom_sel));

    // R12
    low_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !is_sw && !is_upper) |=>
            ($stable(cfg_read_ram) && $stable(cfg_wprot) && $stable(cfg_bank1)));
endmodule

bind upper_bank_switch ubs_checker chk_i (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .ram_addr(ram_addr), .ram_we(ram_we),
    .rom_sel(rom_sel), .cfg_read_ram(cfg_read_ram), .cfg_wprot(cfg_wprot),
    .cfg_bank1(cfg_bank1)
);

// File: tb/upper_bank_switch_tb_top.sv
module upper_bank_switch_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_valid;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [15:0] ram_addr;
    logic        ram_we;
    logic        rom_sel;
    logic        cfg_read_ram;
    logic        cfg_wprot;
    logic        cfg_bank1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    upper_bank_switch dut_i (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .ram_addr(ram_addr), .ram_we(ram_we),
        .rom_sel(rom_sel), .cfg_read_ram(cfg_read_ram), .cfg_wprot(cfg_wprot),
        .cfg_bank1(cfg_bank1)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one access at the falling edge and let it be sampled by the next rising edge
    task automatic access(input logic we, input logic [15:0] a);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_we    = 1'b0;
        cpu_addr  = 16'h0000;
        #1;
    endtask

    task automatic set_mode(input logic [3:0] sel);
        access(1'b0, {12'hC08, sel});
        idle();
    endtask

    task automatic check_cfg(input string req, input logic rr, input logic wp, input logic b1);
        check(req, "read_ram", {31'd0, cfg_read_ram}, {31'd0, rr});
        check(req, "wprot",    {31'd0, cfg_wprot},    {31'd0, wp});
        check(req, "bank1",    {31'd0, cfg_bank1},    {31'd0, b1});
    endtask

    task automatic t_reset();
        rst = 1'b1; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_cfg("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_default_map();
        access(1'b0, 16'hD000);
        check("R2", "rom_sel D000", {31'd0, rom_sel}, 32'd1);
        check("R2", "ram_we D000",  {31'd0, ram_we},  32'd0);
        access(1'b0, 16'hFFFF);
        check("R2", "rom_sel FFFF", {31'd0, rom_sel}, 32'd1);
        access(1'b1, 16'hFFFF);
        check("R3", "ram_we FFFF",  {31'd0, ram_we},  32'd1);
        check("R5", "addr FFFF",    {16'd0, ram_addr}, 32'hFFFF);
        access(1'b1, 16'hD000);
        check("R3", "ram_we D000",  {31'd0, ram_we},  32'd1);
        check("R4", "bank2 D000",   {16'd0, ram_addr}, 32'hD000);
        idle();
    endtask

    task automatic t_switch_table();
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 16; s++) begin
                logic [3:0] sel;
                logic exp_rr, exp_wp;
                string req;
                sel = s[3:0];
                access(w[0], {12'hC08, sel});
                check("R11", "ram_we on switch",  {31'd0, ram_we},  32'd0);
                check("R11", "rom_sel on switch", {31'd0, rom_sel}, 32'd0);
                idle();
                exp_rr = (sel[1:0] == 2'b00) || (sel[1:0] == 2'b11);
                exp_wp = (sel[1:0] == 2'b00) || (sel[1:0] == 2'b10);
                req = sel[2] ? "R8" : "R7";
                check(req,  "read_ram", {31'd0, cfg_read_ram}, {31'd0, exp_rr});
                check(req,  "wprot",    {31'd0, cfg_wprot},    {31'd0, exp_wp});
                check("R6", "bank1",    {31'd0, cfg_bank1},    {31'd0, sel[3]});
            end
        end
    endtask

    task automatic t_bank_mapping();
        set_mode(4'hB);  // bank 1, RAM read, writable
        access(1'b0, 16'hD000);
        check("R10", "rom_sel RAM read", {31'd0, rom_sel}, 32'd0);
        check("R4",  "bank1 D000", {16'd0, ram_addr}, 32'hC000);
        access(1'b1, 16'hDFFF);
        check("R4",  "bank1 DFFF", {16'd0, ram_addr}, 32'hCFFF);
        check("R3",  "ram_we bank1", {31'd0, ram_we}, 32'd1);
        access(1'b0, 16'hE000);
        check("R5",  "fixed E000 bank1", {16'd0, ram_addr}, 32'hE000);
        set_mode(4'h3);  // bank 2, RAM read, writable
        access(1'b0, 16'hD000);
        check("R10", "bank2 D000 after bank change", {16'd0, ram_addr}, 32'hD000);
        check("R10", "rom_sel RAM read bank2", {31'd0, rom_sel}, 32'd0);
        access(1'b0, 16'hE000);
        check("R5",  "fixed E000 bank2", {16'd0, ram_addr}, 32'hE000);
        idle();
    endtask

    task automatic t_protect();
        set_mode(4'h8);  // bank 1, RAM read, protected
        access(1'b1, 16'hD000);
        check("R9", "ram_we D000 protected", {31'd0, ram_we}, 32'd0);
        access(1'b1, 16'hFFFF);
        check("R9", "ram_we FFFF protected", {31'd0, ram_we}, 32'd0);
        set_mode(4'h2);  // bank 2, ROM read, protected
        access(1'b1, 16'hE123);
        check("R9", "ram_we ROM+protected", {31'd0, ram_we}, 32'd0);
        access(1'b0, 16'hE123);
        check("R2", "rom_sel ROM+protected", {31'd0, rom_sel}, 32'd1);
        set_mode(4'h1);  // bank 2, ROM read, writable
        access(1'b1, 16'hD800);
        check("R3", "write-through under ROM read", {31'd0, ram_we}, 32'd1);
        idle();
    endtask

    task automatic t_low_pass();
        set_mode(4'h8);  // known non-default config: RAM, protected, bank 1
        access(1'b1, 16'hC07F);
        check("R12", "addr C07F", {16'd0, ram_addr}, 32'hC07F);
        check("R12", "ram_we C07F", {31'd0, ram_we}, 32'd1);
        access(1'b0, 16'hC090);
        check("R12", "rom_sel C090", {31'd0, rom_sel}, 32'd0);
        check("R12", "ram_we read C090", {31'd0, ram_we}, 32'd0);
        access(1'b1, 16'hCFFF);
        check("R12", "addr CFFF", {16'd0, ram_addr}, 32'hCFFF);
        access(1'b1, 16'h0000);
        check("R12", "addr 0000", {16'd0, ram_addr}, 32'h0000);
        idle();
        check_cfg("R12", 1'b1, 1'b1, 1'b1);
        // idle cycle with switch address but no valid must not change config
        @(negedge clk); cpu_valid = 1'b0; cpu_addr = 16'hC081; #1;
        idle();
        check_cfg("R12", 1'b1, 1'b1, 1'b1);
        // reset again restores the cold configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check_cfg("R1", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_default_map();
        t_switch_table();
        t_bank_mapping();
        t_protect();
        t_low_pass();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule